// File: doc/BRIEF.md
# Bidirectional Row Scan Shift Register

This block is the row-select path of a display driver that runs in common (row) mode. It is a chain of `STAGES` one-bit stages, 160 by default, one for each drive output. A falling edge on the line pulse advances the chain by one stage. A new bit enters the chain from one of two end pins. Which pin is the entry point depends on the direction input. The stage at the far end of the chain drives the other end pin, so several chips can be joined end to end into a longer scan. The contents of the chain appear in parallel as the row-select vector, which feeds the downstream level selection.

The line pulse is an ordinary data input. It is sampled on the system clock, and its falling edge is detected synchronously. A shift takes effect on the first clock edge that samples the line pulse low after it was sampled high. Each end pin is modelled as three signals: an input, an output and an output enable. The direction input is registered, and the roles of the two pins follow the registered value. Shifting happens only while the mode input selects common mode. In the other mode the chain holds its contents.

Top module: `row_scan_shifter`

## Requirements
- R1: A synchronous active-high reset clears every stage, so `row_sel` reads all zeros on the cycle after reset.
- R2: Direction up (`dir`=0). On a detected line-pulse fall in common mode, stage i+1 takes the value of stage i, and stage 0 takes `end_a_i`.
- R3: Direction down (`dir`=1). On a detected line-pulse fall in common mode, stage i takes the value of stage i+1, and stage STAGES-1 takes `end_b_i`.
- R4: The chain is unchanged on every clock edge that is not a line-pulse fall. This covers the pulse held high, held low and rising, whatever the end pins carry at the time.
- R5: While `mode_com`=0 the chain holds its contents, even when the line pulse falls.
- R6: Pin roles follow `dir` one clock after it is sampled. With `dir`=0, `end_b_oe`=1 and `end_a_oe`=0. With `dir`=1, `end_a_oe`=1 and `end_b_oe`=0.
- R7: An enabled end pin carries the far-end stage: `end_b_o`=stage STAGES-1 in direction up, and `end_a_o`=stage 0 in direction down. A bit that enters the chain therefore reaches the opposite pin after STAGES falls.
- R8: A shift appears on `row_sel` exactly one clock after the clock edge that samples the line pulse low following a high sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_pulse | input | 1 | Line pulse; a falling edge advances the chain |
| mode_com | input | 1 | 1 = common mode (shifting enabled), 0 = hold |
| dir | input | 1 | 0 = shift toward higher stages, 1 = toward lower |
| end_a_i | input | 1 | End pin A input value |
| end_a_o | output | 1 | End pin A driven value |
| end_a_oe | output | 1 | End pin A output enable |
| end_b_i | input | 1 | End pin B input value |
| end_b_o | output | 1 | End pin B driven value |
| end_b_oe | output | 1 | End pin B output enable |
| row_sel | output | STAGES | Parallel row-select vector (stage i on bit i) |

## Verification
A wrong stage value shows up on `row_sel` on the cycle after the line-pulse fall that causes it. It also reaches the cascade pin once it has moved to the far end of the chain, which can take up to STAGES falls. A missed or doubled edge detection shifts the whole vector by one position, and every later comparison then fails. A wrong direction register swaps the output enables within one clock. It also makes the next shift run the wrong way, which scrambles the whole pattern.

// File: rtl/row_scan_pkg.sv
package row_scan_pkg;
  typedef enum logic {
    SHIFT_UP   = 1'b0,
    SHIFT_DOWN = 1'b1
  } scan_dir_e;
endpackage

// File: rtl/row_scan_edge.sv
// Line-pulse fall detector and direction register.
module row_scan_edge
  import row_scan_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      line_pulse,
  input  logic      dir_in,
  output logic      step,
  output scan_dir_e dir_q
);
  logic lp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lp_q  <= 1'b0;
      dir_q <= SHIFT_UP;
    end else begin
      lp_q  <= line_pulse;
      dir_q <= scan_dir_e'(dir_in);
    end
  end

  assign step = lp_q & ~line_pulse;
endmodule

// File: rtl/row_scan_chain.sv
// Stage chain; each stage picks its lower or upper neighbour.
module row_scan_chain
  import row_scan_pkg::*;
#(
  parameter int STAGES = 160
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              enable,
  input  scan_dir_e         dir_q,
  input  logic              fill_lo,
  input  logic              fill_hi,
  output logic [STAGES-1:0] q
);
  localparam int LAST = STAGES - 1;

  for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
    logic from_lo;
    logic from_hi;
    logic stage_q;

    if (gi == 0) begin : g_lo_end
      assign from_lo = fill_lo;
    end else begin : g_lo_mid
      assign from_lo = q[gi-1];
    end

    if (gi == LAST) begin : g_hi_end
      assign from_hi = fill_hi;
    end else begin : g_hi_mid
      assign from_hi = q[gi+1];
    end

    always_ff @(posedge clk) begin
      if (rst)
        stage_q <= 1'b0;
      else if (step && enable)
        stage_q <= (dir_q == SHIFT_DOWN) ? from_hi : from_lo;
    end

    assign q[gi] = stage_q;
  end
endmodule

// File: rtl/row_scan_pins.sv
// Role assignment of the two shared end pins.
module row_scan_pins
  import row_scan_pkg::*;
#(
  parameter int STAGES = 160
) (
  input  scan_dir_e         dir_q,
  input  logic [STAGES-1:0] q,
  input  logic              a_in,
  input  logic              b_in,
  output logic              fill_lo,
  output logic              fill_hi,
  output logic              a_out,
  output logic              a_oe,
  output logic              b_out,
  output logic              b_oe
);
  localparam int LAST = STAGES - 1;

  always_comb begin
    fill_lo = a_in;
    fill_hi = b_in;
    a_oe    = (dir_q == SHIFT_DOWN);
    b_oe    = (dir_q == SHIFT_UP);
    a_out   = a_oe ? q[0]    : 1'b0;
    b_out   = b_oe ? q[LAST] : 1'b0;
  end
endmodule

// File: rtl/row_scan_shifter.sv
module row_scan_shifter
  import row_scan_pkg::*;
#(
  parameter int STAGES = 160
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_pulse,
  input  logic              mode_com,
  input  logic              dir,
  input  logic              end_a_i,
  output logic              end_a_o,
  output logic              end_a_oe,
  input  logic              end_b_i,
  output logic              end_b_o,
  output logic              end_b_oe,
  output logic [STAGES-1:0] row_sel
);
  logic      step;
  scan_dir_e dir_q;
  logic      fill_lo;
  logic      fill_hi;

  row_scan_edge u_edge (
    .clk        (clk),
    .rst        (rst),
    .line_pulse (line_pulse),
    .dir_in     (dir),
    .step       (step),
    .dir_q      (dir_q)
  );

  row_scan_pins #(.STAGES(STAGES)) u_pins (
    .dir_q   (dir_q),
    .q       (row_sel),
    .a_in    (end_a_i),
    .b_in    (end_b_i),
    .fill_lo (fill_lo),
    .fill_hi (fill_hi),
    .a_out   (end_a_o),
    .a_oe    (end_a_oe),
    .b_out   (end_b_o),
    .b_oe    (end_b_oe)
  );

  row_scan_chain #(.STAGES(STAGES)) u_chain (
    .clk     (clk),
    .rst     (rst),
    .step    (step),
    .enable  (mode_com),
    .dir_q   (dir_q),
    .fill_lo (fill_lo),
    .fill_hi (fill_hi),
    .q       (row_sel)
  );
endmodule

// File: rtl/row_scan_chk.sv
module row_scan_chk #(
  parameter int STAGES = 160
) (
  input logic              clk,
  input logic              rst,
  input logic              line_pulse,
  input logic              mode_com,
  input logic              dir,
  input logic              end_a_i,
  input logic              end_a_o,
  input logic              end_a_oe,
  input logic              end_b_i,
  input logic              end_b_o,
  input logic              end_b_oe,
  input logic [STAGES-1:0] row_sel
);
  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> (row_sel == '0));

  // R2
  shift_up_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(line_pulse) && !line_pulse && mode_com && end_b_oe)
    |=> (row_sel == {$past(row_sel[STAGES-2:0]), $past(end_a_i)}));

  // R3
  shift_down_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(line_pulse) && !line_pulse && mode_com && end_a_oe)
    |=> (row_sel == {$past(end_b_i), $past(row_sel[STAGES-1:1])}));

  // R4
  no_edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !($past(line_pulse) && !line_pulse) |=> $stable(row_sel));

  // R5
  seg_mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_com |=> $stable(row_sel));

  // R6
  pin_role_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (end_a_oe == $past(dir)) && (end_b_oe == !$past(dir)));

  // R7
  b_cascade_chk: assert property (@(posedge clk) disable iff (rst)
    end_b_oe |-> (end_b_o == row_sel[STAGES-1]));

  // R7
  a_cascade_chk: assert property (@(posedge clk) disable iff (rst)
    end_a_oe |-> (end_a_o == row_sel[0]));
endmodule

bind row_scan_shifter row_scan_chk #(.STAGES(STAGES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .line_pulse (line_pulse),
  .mode_com   (mode_com),
  .dir        (dir),
  .end_a_i    (end_a_i),
  .end_a_o    (end_a_o),
  .end_a_oe   (end_a_oe),
  .end_b_i    (end_b_i),
  .end_b_o    (end_b_o),
  .end_b_oe   (end_b_oe),
  .row_sel    (row_sel)
);

// File: tb/row_scan_shifter_tb.sv
`timescale 1ns/1ps
module row_scan_shifter_tb;
  localparam int SN = 8;
  localparam int FN = 160;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lp = 1'b0;
  logic mode = 1'b0;
  logic dir = 1'b0;
  logic a_i = 1'b0;
  logic b_i = 1'b0;
  logic f_a = 1'b0;
  logic a_o, a_oe, b_o, b_oe;
  logic fa_o, fa_oe, fb_o, fb_oe;
  logic [SN-1:0] row;
  logic [FN-1:0] frow;
  logic [SN-1:0] exp_row;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  row_scan_shifter #(.STAGES(SN)) u_dut (
    .clk(clk), .rst(rst), .line_pulse(lp), .mode_com(mode), .dir(dir),
    .end_a_i(a_i), .end_a_o(a_o), .end_a_oe(a_oe),
    .end_b_i(b_i), .end_b_o(b_o), .end_b_oe(b_oe), .row_sel(row)
  );

  row_scan_shifter #(.STAGES(FN)) u_full (
    .clk(clk), .rst(rst), .line_pulse(lp), .mode_com(mode), .dir(dir),
    .end_a_i(f_a), .end_a_o(fa_o), .end_a_oe(fa_oe),
    .end_b_i(1'b0), .end_b_o(fb_o), .end_b_oe(fb_oe), .row_sel(frow)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exv);
    checks++;
    if (act !== exv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exv, $time);
    end
  endtask

  task automatic check_pins(input string req);
    chk(req, {63'd0, a_oe}, {63'd0, dir});
    chk(req, {63'd0, b_oe}, {63'd0, !dir});
    if (dir) chk(req, {63'd0, a_o}, {63'd0, exp_row[0]});
    else     chk(req, {63'd0, b_o}, {63'd0, exp_row[SN-1]});
  endtask

  // One line pulse: high for one cycle, then low; shift lands one clock later.
  task automatic pulse(input logic d, input logic m, input logic a, input logic b, input string req);
    @(negedge clk);
    lp = 1'b1; dir = d; mode = m; a_i = a; b_i = b;
    @(negedge clk);
    lp = 1'b0;
    chk({req, "/R8 pre"}, {{(64-SN){1'b0}}, row}, {{(64-SN){1'b0}}, exp_row});
    @(negedge clk);
    if (m) begin
      if (d) exp_row = {b, exp_row[SN-1:1]};
      else   exp_row = {exp_row[SN-2:0], a};
    end
    chk(req, {{(64-SN){1'b0}}, row}, {{(64-SN){1'b0}}, exp_row});
    check_pins("R6/R7");
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    exp_row = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1", {{(64-SN){1'b0}}, row}, 64'd0);
    chk("R1", {63'd0, |frow}, 64'd0);
    check_pins("R6");

    // Sweep over direction, mode and data patterns.
    for (int i = 0; i < 640; i++) begin
      logic d, m, a, b;
      d = i[5];
      m = ((i % 7) != 3);
      a = (((i * 13 + 5) % 7) < 3);
      b = (((i * 11 + 2) % 5) < 2);
      pulse(d, m, a, b, !m ? "R5" : (d ? "R3" : "R2"));
    end

    // R4: line pulse held low with changing pins
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      a_i = k[0]; b_i = !k[0]; mode = 1'b1;
      chk("R4 low", {{(64-SN){1'b0}}, row}, {{(64-SN){1'b0}}, exp_row});
    end
    // R4: rising then held high
    @(negedge clk);
    lp = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      a_i = k[1]; b_i = k[0];
      chk("R4 high", {{(64-SN){1'b0}}, row}, {{(64-SN){1'b0}}, exp_row});
    end
    @(negedge clk);
    lp = 1'b0;
    @(negedge clk);
    if (dir) exp_row = {b_i, exp_row[SN-1:1]};
    else     exp_row = {exp_row[SN-2:0], a_i};
    chk("R4 fall", {{(64-SN){1'b0}}, row}, {{(64-SN){1'b0}}, exp_row});

    // R5: fall in segment mode leaves both chains alone
    pulse(1'b0, 1'b0, 1'b1, 1'b1, "R5");

    // R7: a single one travels the full-size chain to pin B
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    exp_row = '0;
    chk("R1", {63'd0, |frow}, 64'd0);
    for (int p = 1; p <= FN; p++) begin
      f_a = (p == 1);
      pulse(1'b0, 1'b1, 1'b0, 1'b0, "R2");
      chk("R7 cascade", {63'd0, fb_o}, {63'd0, (p == FN)});
      if (p == FN) chk("R7 row", {63'd0, frow[FN-1]}, 64'd1);
    end
    // R3/R7: reverse; the one travels back down to pin A
    for (int p = 1; p <= FN; p++) begin
      pulse(1'b1, 1'b1, 1'b0, 1'b0, "R3");
      chk("R7 cascade down", {63'd0, fa_o}, {63'd0, (p == FN - 1)});
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule